// File: doc/BRIEF.md
# Parking Occupancy Up/Down Controller

This block keeps a running count of the vehicles inside a car park that holds at most 100 of them. The count is kept as two cascaded decimal (BCD) digits, so it is a modulus-100 up/down counter. A separate full flag stands for the hundredth vehicle. An entry sensor pulse adds one vehicle and an exit sensor pulse removes one. The full state drives a lamp and the command that lowers the entry barrier. Below capacity the lamp is dark and the barrier is raised.

Both sensor inputs are single-cycle pulses, already debounced, and are sampled on the rising clock edge. Occupancy equals 100 times the full flag plus the two-digit BCD value. When the hundredth vehicle arrives, the digits roll over to 00 and the flag sets. The first exit after that clears the flag and borrows the digits down to 99. The count saturates at both ends: entries are refused while the lot is full, and exits are refused while the lot is empty. The number of digits is a parameter, and the capacity is ten to that power.

Top module: `parking_occupancy`

## Requirements
- R1: A synchronous active-high reset sets the BCD count to 00 and clears the full flag. The lamp and barrier outputs are then 0.
- R2: Below capacity, an entry pulse with no exit pulse raises occupancy by one. Each BCD digit always stays in the range 0 to 9.
- R3: With occupancy above zero, an exit pulse with no entry pulse lowers occupancy by one.
- R4: When counting up, a ones digit of 9 goes to 0 and the tens digit rises by one.
- R5: When counting down, a ones digit of 0 goes to 9 and the tens digit falls by one.
- R6: An entry pulse at count 99 with the flag clear gives count 00 with the full flag set.
- R7: lot_full and gate_lower are both 1 exactly when occupancy is 100, and the BCD count then reads 00. Below 100 both outputs are 0, which means the barrier is raised.
- R8: An entry pulse while full is ignored. The count stays 00 and the outputs stay 1.
- R9: An exit pulse while full clears the full flag and sets the count to 99.
- R10: An exit pulse at count 00 with the flag clear is ignored.
- R11: Entry and exit pulses in the same cycle leave the count and the flag unchanged.
- R12: The outputs change only after the rising edge that samples a pulse. They are registered, with one cycle of latency and no combinational path from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_pulse | input | 1 | One-cycle pulse, vehicle entered |
| exit_pulse | input | 1 | One-cycle pulse, vehicle left |
| occupancy_bcd | output | 4*DIGITS (8) | BCD count; ones digit in bits [3:0], tens in [7:4] |
| lot_full | output | 1 | Full lamp, 1 at capacity |
| gate_lower | output | 1 | 1 commands the entry barrier down, 0 raises it |

## Verification
The bench checks the places where the block is most likely to go wrong.

- Each tens boundary, in both directions. A missing carry would go from 19 to 10, and a missing borrow would go from 20 to 29.
- The step from 99 to full. A design without the separate flag would wrap silently to 00 with the lamp dark.
- The step back from full to 99. A design that forgot to borrow would read 00 with the flag clear, which looks like an empty lot.
- Extra entries at capacity and extra exits at zero. A non-saturating design would roll over to 01 or 99.
- Simultaneous pulses, at empty, at full and mid-range. A design that gives one input priority would drift.

A long pseudo-random pulse sequence is compared against an arithmetic occupancy model, and a mid-run reset is also checked.

// File: rtl/parking_pkg.sv
package parking_pkg;

    typedef logic [3:0] bcd_t;

    localparam bcd_t BCD_TOP    = 4'd9;
    localparam bcd_t BCD_BOTTOM = 4'd0;

    typedef enum logic [1:0] {
        MOVE_HOLD = 2'b00,
        MOVE_UP   = 2'b01,
        MOVE_DOWN = 2'b10
    } move_e;

    typedef struct packed {
        logic en;
        logic up;
    } step_cmd_t;

    function automatic bcd_t bcd_step(input bcd_t d, input logic up);
        if (up)
            return (d == BCD_TOP) ? BCD_BOTTOM : bcd_t'(d + 4'd1);
        else
            return (d == BCD_BOTTOM) ? BCD_TOP : bcd_t'(d - 4'd1);
    endfunction

    function automatic logic bcd_terminal(input bcd_t d, input logic up);
        return up ? (d == BCD_TOP) : (d == BCD_BOTTOM);
    endfunction

endpackage

// File: rtl/bcd_decade_stage.sv
module bcd_decade_stage
    import parking_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic step_en,
    input  logic step_up,
    output bcd_t digit,
    output logic terminal
);

    bcd_t digit_q;

    always_ff @(posedge clk) begin
        if (rst)
            digit_q <= BCD_BOTTOM;
        else if (step_en)
            digit_q <= bcd_step(digit_q, step_up);
    end

    assign digit    = digit_q;
    assign terminal = bcd_terminal(digit_q, step_up);

    assert_bcd_range_R2: assert property (@(posedge clk) disable iff (rst)
        digit_q <= BCD_TOP);

    assert_carry_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (step_en && step_up && digit_q == BCD_TOP) |=> digit_q == BCD_BOTTOM);

    assert_borrow_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !step_up && digit_q == BCD_BOTTOM) |=> digit_q == BCD_TOP);

endmodule

// File: rtl/occupancy_ctrl.sv
module occupancy_ctrl
    import parking_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      entry_pulse,
    input  logic      exit_pulse,
    input  logic      digits_all_top,
    input  logic      digits_all_zero,
    output step_cmd_t cmd,
    output logic      full
);

    logic  full_q;
    move_e move;

    always_comb begin
        move = MOVE_HOLD;
        if (entry_pulse && !exit_pulse && !full_q)
            move = MOVE_UP;
        else if (exit_pulse && !entry_pulse && (full_q || !digits_all_zero))
            move = MOVE_DOWN;
    end

    always_comb begin
        cmd.en = (move != MOVE_HOLD);
        cmd.up = (move == MOVE_UP);
    end

    always_ff @(posedge clk) begin
        if (rst)
            full_q <= 1'b0;
        else if (move == MOVE_UP && digits_all_top)
            full_q <= 1'b1;
        else if (move == MOVE_DOWN)
            full_q <= 1'b0;
    end

    assign full = full_q;

    assert_full_set_R6: assert property (@(posedge clk) disable iff (rst)
        (!full_q && entry_pulse && !exit_pulse && digits_all_top) |=> full_q);

    assert_full_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (full_q && entry_pulse && !exit_pulse) |=> full_q);

    assert_full_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (full_q && exit_pulse && !entry_pulse) |=> !full_q);

endmodule

// File: rtl/parking_occupancy.sv
module parking_occupancy
    import parking_pkg::*;
#(
    parameter int DIGITS = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  entry_pulse,
    input  logic                  exit_pulse,
    output logic [4*DIGITS-1:0]   occupancy_bcd,
    output logic                  lot_full,
    output logic                  gate_lower
);

    localparam int CNT_W = 4 * DIGITS;

    step_cmd_t         cmd;
    logic              full;
    logic [DIGITS:0]   chain_en;
    logic [DIGITS-1:0] term;
    logic [DIGITS-1:0] is_top;
    logic [DIGITS-1:0] is_zero;
    bcd_t              digit [DIGITS];

    assign chain_en[0] = cmd.en;

    for (genvar i = 0; i < DIGITS; i++) begin : g_decade
        bcd_decade_stage u_stage (
            .clk      (clk),
            .rst      (rst),
            .step_en  (chain_en[i]),
            .step_up  (cmd.up),
            .digit    (digit[i]),
            .terminal (term[i])
        );
        assign chain_en[i+1]       = chain_en[i] & term[i];
        assign is_top[i]           = (digit[i] == BCD_TOP);
        assign is_zero[i]          = (digit[i] == BCD_BOTTOM);
        assign occupancy_bcd[4*i +: 4] = digit[i];
    end

    occupancy_ctrl u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .entry_pulse     (entry_pulse),
        .exit_pulse      (exit_pulse),
        .digits_all_top  (&is_top),
        .digits_all_zero (&is_zero),
        .cmd             (cmd),
        .full            (full)
    );

    assign lot_full   = full;
    assign gate_lower = full;

    assert_full_digits_R7: assert property (@(posedge clk) disable iff (rst)
        lot_full |-> occupancy_bcd == '0);

    assert_empty_exit_R10: assert property (@(posedge clk) disable iff (rst)
        (!lot_full && occupancy_bcd == '0 && exit_pulse && !entry_pulse)
        |=> (occupancy_bcd == '0 && !lot_full));

    assert_tie_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (entry_pulse && exit_pulse) |=> ($stable(occupancy_bcd) && $stable(lot_full)));

    assert_width_R12: assert property (@(posedge clk) disable iff (rst)
        (!entry_pulse && !exit_pulse) |=> ($stable(occupancy_bcd) && $stable(lot_full)));

    if (CNT_W != 4 * DIGITS) begin : g_bad_width
        initial $display("width mismatch");
    end

endmodule

// File: tb/tb_parking_occupancy.sv
module tb_parking_occupancy;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       entry_pulse = 1'b0;
    logic       exit_pulse = 1'b0;
    logic [7:0] occupancy_bcd;
    logic       lot_full;
    logic       gate_lower;

    int checks = 0;
    int fails  = 0;
    int occ    = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    parking_occupancy #(.DIGITS(2)) dut (
        .clk           (clk),
        .rst           (rst),
        .entry_pulse   (entry_pulse),
        .exit_pulse    (exit_pulse),
        .occupancy_bcd (occupancy_bcd),
        .lot_full      (lot_full),
        .gate_lower    (gate_lower)
    );

    function automatic logic [7:0] exp_bcd(input int o);
        int r;
        r = o % 100;
        return {4'(r / 10), 4'(r % 10)};
    endfunction

    task automatic check(input string tag, input int got, input int expv);
        checks++;
        if (got != expv) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, got, expv);
        end
    endtask

    task automatic check_state(input string tag);
        check(tag, int'(occupancy_bcd), int'(exp_bcd(occ)));
        check({tag, "/R7 lamp"}, int'(lot_full), int'(occ == 100));
        check({tag, "/R7 gate"}, int'(gate_lower), int'(occ == 100));
    endtask

    task automatic pulse(input logic en, input logic ex);
        string tag;
        if (en && ex)                    tag = "R11";
        else if (en && occ == 100)       tag = "R8";
        else if (ex && occ == 100)       tag = "R9";
        else if (ex && occ == 0)         tag = "R10";
        else if (en && occ == 99)        tag = "R6";
        else if (en && occ % 10 == 9)    tag = "R4";
        else if (ex && occ % 10 == 0)    tag = "R5";
        else if (en)                     tag = "R2";
        else if (ex)                     tag = "R3";
        else                             tag = "R12 idle";
        @(negedge clk);
        entry_pulse = en;
        exit_pulse  = ex;
        #1;
        check_state("R12 before edge");
        @(posedge clk);
        #1;
        entry_pulse = 1'b0;
        exit_pulse  = 1'b0;
        if (en && !ex && occ < 100) occ++;
        else if (ex && !en && occ > 0) occ--;
        check_state(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        occ = 0;
        check_state("R1");
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        for (int i = 0; i < 100; i++) pulse(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b0);
        for (int i = 0; i < 100; i++) pulse(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1);
        pulse(1'b1, 1'b1);
        pulse(1'b0, 1'b0);
        for (int i = 0; i < 45; i++) pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b1);
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pulse(lfsr[0] | lfsr[3], lfsr[1] & lfsr[2]);
        end
        do_reset();
        for (int i = 0; i < 12; i++) pulse(1'b1, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule